// File: doc/BRIEF.md
# Trap Entry and Vectoring Unit

This block decides, for one processor core, how a trap is entered and where execution goes next. Each cycle it looks at an exception request from the pipeline (a major cause code, a subcode and the PC of the instruction that trapped). Alongside the request it sees a flag marking the trap as a translation-refill miss, the current privilege and interrupt-enable state, the debug-mode flag and the external interrupt pending and mask fields. One cycle later it presents a redirect PC and write strobes with next-state values for the saved-state registers that the surrounding control-register file owns.

There are three entry paths. A normal entry saves the current mode into the ordinary previous-mode register and records the cause and return address. A refill entry saves the mode into a separate refill set and switches to direct addressing. A debug entry saves the PC into the debug return register and marks debug mode active, without touching the normal mode. Interrupts and exceptions are vectored from a common entry base with a programmable spacing. An interrupt request that arrives while debug mode is active is sent down the debug path instead.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, every strobe output (redirect, error and all write enables) is 0.
- R2: With no exception request, an interrupt is taken only when the interrupt enable is 1, debug mode is inactive and the AND of the pending and mask fields is nonzero. Otherwise no redirect occurs.
- R3: A taken interrupt uses the highest-numbered set bit of pending AND mask as its vector. The redirect PC is entry_base + (64 + vector) * spacing, and the status cause written is 0 with subcode 0.
- R4: Spacing is 0 when the vector-size field is 0. Otherwise it is 4 shifted left by the vector-size field, in bytes.
- R5: Cause codes are: 0 interrupt, 1 load page invalid, 2 store page invalid, 3 fetch page invalid, 4 page modified, 5 not readable, 6 not executable, 7 page privilege, 8 address error (subcode 0 fetch, otherwise data), 9 bound check, 11 syscall, 12 break, 13 illegal instruction, 14 instruction privilege, 15 FP disabled, 16 128-bit vector disabled, 17 256-bit vector disabled, 18 FP exception, 26 debug breakpoint. Every other code is unsupported. A supported non-interrupt, non-debug, non-refill exception redirects to entry_base + code * spacing, writes code and subcode to status and writes the trapping PC as return address.
- R6: On a refill-flagged normal entry, privilege and enable go to the refill save register. The direct-address/paging-off strobe fires, the return value PC >> 2 is written to the refill return register, no status or ordinary return-address write happens, and an exception redirects to refill_base.
- R7: A non-refill normal entry saves the current privilege and interrupt enable into the ordinary previous-mode register.
- R8: Every normal or refill entry asserts the mode write that forces privilege 0 and interrupts disabled; debug entries never assert it.
- R9: A debug breakpoint (code 26) sets the debug-cause-valid bit, writes debug code 0xC, saves the PC to the debug return register, sets debug mode and redirects to entry_base + 0x480, regardless of the refill flag.
- R10: An interrupt request (code 0) while debug mode is active sets the debug-interrupt bit and takes the debug entry to entry_base + 0x480, with no normal state saved.
- R11: The bad-address write fires, with the PC, for codes 11 to 18. Bad-instruction capture is requested for every supported cause except interrupt, fetch page invalid (3) and fetch address error (8 with subcode 0).
- R12: An unsupported code asserts the error output and no redirect or write strobe.
- R13: Outputs are registered, so the redirect appears exactly in the cycle after the request. It lasts one cycle per accepted request and returns to 0 when no request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request present this cycle |
| req_code | input | 6 | Major cause code |
| req_sub | input | 9 | Cause subcode |
| cur_pc | input | XLEN | PC at which the trap is taken |
| refill | input | 1 | Trap is a translation-refill miss |
| cur_plv | input | 2 | Current privilege level |
| cur_ie | input | 1 | Current global interrupt enable |
| dbg_active | input | 1 | Debug mode active |
| irq_pend | input | NIRQ | Interrupt pending bits |
| irq_mask | input | NIRQ | Interrupt local enables |
| vec_size | input | VS_W | Vector spacing field |
| entry_base | input | XLEN | Common entry base |
| refill_base | input | XLEN | Refill entry address |
| o_redirect | output | 1 | Redirect strobe |
| o_redirect_pc | output | XLEN | New PC |
| o_err | output | 1 | Unsupported cause |
| o_crmd_we | output | 1 | Force privilege 0, interrupts off |
| o_dapg_we | output | 1 | Set direct addressing, clear paging |
| o_prmd_we | output | 1 | Write ordinary previous-mode register |
| o_rprmd_we | output | 1 | Write refill previous-mode register |
| o_sv_plv | output | 2 | Saved privilege value |
| o_sv_ie | output | 1 | Saved interrupt enable value |
| o_era_we | output | 1 | Write ordinary return address |
| o_epc | output | XLEN | Trapping PC (return, bad-address or debug return value) |
| o_rera_we | output | 1 | Write refill return register |
| o_rera | output | XLEN | PC >> 2 |
| o_stat_we | output | 1 | Write cause and subcode |
| o_ecode | output | 6 | Cause value |
| o_esub | output | 9 | Subcode value |
| o_badv_we | output | 1 | Write bad address with PC |
| o_badi_req | output | 1 | Request bad-instruction capture |
| o_dbg_we | output | 1 | Enter debug: set debug mode, save debug return |
| o_dbg_dcl | output | 1 | Set debug-cause-valid |
| o_dbg_dei | output | 1 | Set debug-interrupt |
| o_dbg_code | output | 6 | Debug code value |

## Verification
The hardest situation to reach is one where two entry paths could claim the same event: an interrupt-coded request while debug mode is active, a debug breakpoint with the refill flag set, and a refill-flagged exception while an interrupt is pending and enabled. The stimulus sets up each of these conflicts on purpose, and the scoreboard checks that only one path's strobes fire. Vector selection is driven with pending patterns whose highest set bit is cleared by the mask, so a priority pick that ignored the mask would give a different address.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int CODE_W = 6;
    localparam int SUB_W  = 9;
    localparam logic [CODE_W-1:0] DBG_BP_CODE = 6'hC;

    typedef enum logic [CODE_W-1:0] {
        C_INT   = 6'd0,
        C_LDPG  = 6'd1,
        C_STPG  = 6'd2,
        C_IFPG  = 6'd3,
        C_MOD   = 6'd4,
        C_NRD   = 6'd5,
        C_NEX   = 6'd6,
        C_PPRV  = 6'd7,
        C_ADDR  = 6'd8,
        C_BND   = 6'd9,
        C_SYS   = 6'd11,
        C_BRK   = 6'd12,
        C_ILL   = 6'd13,
        C_IPRV  = 6'd14,
        C_FPD   = 6'd15,
        C_VD128 = 6'd16,
        C_VD256 = 6'd17,
        C_FPE   = 6'd18,
        C_DBP   = 6'd26
    } cause_e;

    typedef enum logic [1:0] {
        VS_EXC = 2'd0,
        VS_INT = 2'd1,
        VS_DBG = 2'd2
    } vsel_e;

    typedef struct packed {
        logic ok;
        logic is_int;
        logic is_dbp;
        logic set_badv;
        logic no_badi;
    } cls_t;

    typedef struct packed {
        logic              redirect;
        logic              err;
        logic              crmd_we;
        logic              dapg_we;
        logic              prmd_we;
        logic              rprmd_we;
        logic              era_we;
        logic              rera_we;
        logic              stat_we;
        logic              badv_we;
        logic              badi_req;
        logic              dbg_we;
        logic              dcl;
        logic              dei;
        logic [1:0]        sv_plv;
        logic              sv_ie;
        logic [CODE_W-1:0] ecode;
        logic [SUB_W-1:0]  esub;
        logic [CODE_W-1:0] dcode;
    } ctl_t;

    function automatic cls_t classify(input logic [CODE_W-1:0] code,
                                      input logic [SUB_W-1:0]  sub);
        cls_t c;
        c = '0;
        case (cause_e'(code))
            C_INT: begin
                c.ok      = 1'b1;
                c.is_int  = 1'b1;
                c.no_badi = 1'b1;
            end
            C_IFPG: begin
                c.ok      = 1'b1;
                c.no_badi = 1'b1;
            end
            C_ADDR: begin
                c.ok      = 1'b1;
                c.no_badi = (sub == '0);
            end
            C_LDPG, C_STPG, C_MOD, C_NRD, C_NEX, C_PPRV, C_BND: begin
                c.ok = 1'b1;
            end
            C_SYS, C_BRK, C_ILL, C_IPRV, C_FPD, C_VD128, C_VD256, C_FPE: begin
                c.ok       = 1'b1;
                c.set_badv = 1'b1;
            end
            C_DBP: begin
                c.ok     = 1'b1;
                c.is_dbp = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/trap_irq_pick.sv
module trap_irq_pick #(
    parameter int NIRQ  = 13,
    localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic [NIRQ-1:0]  pend,
    input  logic [NIRQ-1:0]  mask,
    output logic             hit,
    output logic [IDX_W-1:0] vec
);
    logic [NIRQ-1:0] act;

    always_comb begin
        act = pend & mask;
        hit = |act;
        vec = '0;
        // Ascending scan: the last set bit seen, the highest, wins.
        for (int i = 0; i < NIRQ; i++) begin
            if (act[i]) vec = IDX_W'(i);
        end
    end
endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc
    import trap_pkg::*;
#(
    parameter int                XLEN     = 32,
    parameter int                VS_W     = 3,
    parameter int                IDX_W    = 4,
    parameter int                INT_BASE = 64,
    parameter logic [XLEN-1:0]   DBG_OFS  = 'h480
) (
    input  logic [XLEN-1:0]   base,
    input  logic [VS_W-1:0]   vs,
    input  logic [CODE_W-1:0] code,
    input  logic [IDX_W-1:0]  vec,
    input  vsel_e             sel,
    output logic [XLEN-1:0]   addr
);
    logic [XLEN-1:0] spacing;
    logic [XLEN-1:0] slot;

    always_comb begin
        spacing = (vs == '0) ? '0 : (XLEN'(4) << vs);
        slot    = '0;
        addr    = base;
        case (sel)
            VS_INT: begin
                slot = XLEN'(INT_BASE) + XLEN'(vec);
                addr = base + slot * spacing;
            end
            VS_EXC: begin
                slot = XLEN'(code);
                addr = base + slot * spacing;
            end
            VS_DBG:  addr = base + DBG_OFS;
            default: addr = base;
        endcase
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              NIRQ     = 13,
    parameter int              VS_W     = 3,
    parameter int              INT_BASE = 64,
    parameter logic [XLEN-1:0] DBG_OFS  = 'h480
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [5:0]          req_code,
    input  logic [8:0]          req_sub,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic                refill,
    input  logic [1:0]          cur_plv,
    input  logic                cur_ie,
    input  logic                dbg_active,
    input  logic [NIRQ-1:0]     irq_pend,
    input  logic [NIRQ-1:0]     irq_mask,
    input  logic [VS_W-1:0]     vec_size,
    input  logic [XLEN-1:0]     entry_base,
    input  logic [XLEN-1:0]     refill_base,
    output logic                o_redirect,
    output logic [XLEN-1:0]     o_redirect_pc,
    output logic                o_err,
    output logic                o_crmd_we,
    output logic                o_dapg_we,
    output logic                o_prmd_we,
    output logic                o_rprmd_we,
    output logic [1:0]          o_sv_plv,
    output logic                o_sv_ie,
    output logic                o_era_we,
    output logic [XLEN-1:0]     o_epc,
    output logic                o_rera_we,
    output logic [XLEN-1:0]     o_rera,
    output logic                o_stat_we,
    output logic [5:0]          o_ecode,
    output logic [8:0]          o_esub,
    output logic                o_badv_we,
    output logic                o_badi_req,
    output logic                o_dbg_we,
    output logic                o_dbg_dcl,
    output logic                o_dbg_dei,
    output logic [5:0]          o_dbg_code
);
    localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    cls_t             cls;
    logic             irq_hit;
    logic [IDX_W-1:0] irq_vec;
    logic             take_irq, req_int, go_int, go_dint, go_bp, go_exc;
    vsel_e            vsel;
    logic [XLEN-1:0]  vec_addr;
    ctl_t             ctl_d, ctl_q;
    logic [XLEN-1:0]  rpc_d, rpc_q, epc_q, rera_q;

    trap_irq_pick #(.NIRQ(NIRQ)) u_pick (
        .pend (irq_pend),
        .mask (irq_mask),
        .hit  (irq_hit),
        .vec  (irq_vec)
    );

    trap_vec_calc #(
        .XLEN     (XLEN),
        .VS_W     (VS_W),
        .IDX_W    (IDX_W),
        .INT_BASE (INT_BASE),
        .DBG_OFS  (DBG_OFS)
    ) u_vec (
        .base (entry_base),
        .vs   (vec_size),
        .code (req_code),
        .vec  (irq_vec),
        .sel  (vsel),
        .addr (vec_addr)
    );

    always_comb begin
        cls      = classify(req_code, req_sub);
        take_irq = !req_valid && cur_ie && !dbg_active && irq_hit;
        req_int  = req_valid && cls.is_int;
        go_dint  = req_int && dbg_active;
        go_int   = take_irq || (req_int && !dbg_active);
        go_bp    = req_valid && cls.is_dbp;
        go_exc   = req_valid && cls.ok && !cls.is_int && !cls.is_dbp;

        if (go_dint || go_bp) vsel = VS_DBG;
        else if (go_int)      vsel = VS_INT;
        else                  vsel = VS_EXC;

        ctl_d     = '0;
        rpc_d     = vec_addr;
        ctl_d.err = req_valid && !cls.ok;

        if (go_dint || go_bp) begin
            ctl_d.redirect = 1'b1;
            ctl_d.dbg_we   = 1'b1;
            ctl_d.dcl      = go_bp;
            ctl_d.dei      = go_dint;
            ctl_d.dcode    = go_bp ? DBG_BP_CODE : '0;
            ctl_d.badi_req = go_bp;
        end else if (go_int || go_exc) begin
            ctl_d.redirect = 1'b1;
            ctl_d.crmd_we  = 1'b1;
            ctl_d.sv_plv   = cur_plv;
            ctl_d.sv_ie    = cur_ie;
            ctl_d.badv_we  = go_exc && cls.set_badv;
            ctl_d.badi_req = go_exc && !cls.no_badi;
            if (refill) begin
                ctl_d.rprmd_we = 1'b1;
                ctl_d.dapg_we  = 1'b1;
                ctl_d.rera_we  = 1'b1;
                if (go_exc) rpc_d = refill_base;
            end else begin
                ctl_d.prmd_we = 1'b1;
                ctl_d.stat_we = 1'b1;
                ctl_d.era_we  = 1'b1;
                ctl_d.ecode   = go_int ? CODE_W'(C_INT) : req_code;
                ctl_d.esub    = go_int ? '0 : req_sub;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            rpc_q  <= '0;
            epc_q  <= '0;
            rera_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            rpc_q  <= rpc_d;
            epc_q  <= cur_pc;
            rera_q <= cur_pc >> 2;
        end
    end

    assign o_redirect    = ctl_q.redirect;
    assign o_redirect_pc = rpc_q;
    assign o_err         = ctl_q.err;
    assign o_crmd_we     = ctl_q.crmd_we;
    assign o_dapg_we     = ctl_q.dapg_we;
    assign o_prmd_we     = ctl_q.prmd_we;
    assign o_rprmd_we    = ctl_q.rprmd_we;
    assign o_sv_plv      = ctl_q.sv_plv;
    assign o_sv_ie       = ctl_q.sv_ie;
    assign o_era_we      = ctl_q.era_we;
    assign o_epc         = epc_q;
    assign o_rera_we     = ctl_q.rera_we;
    assign o_rera        = rera_q;
    assign o_stat_we     = ctl_q.stat_we;
    assign o_ecode       = ctl_q.ecode;
    assign o_esub        = ctl_q.esub;
    assign o_badv_we     = ctl_q.badv_we;
    assign o_badi_req    = ctl_q.badi_req;
    assign o_dbg_we      = ctl_q.dbg_we;
    assign o_dbg_dcl     = ctl_q.dcl;
    assign o_dbg_dei     = ctl_q.dei;
    assign o_dbg_code    = ctl_q.dcode;
endmodule

// File: rtl/trap_entry_sva.sv
module trap_entry_sva #(
    parameter int NIRQ = 13
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            refill,
    input logic            cur_ie,
    input logic            dbg_active,
    input logic [NIRQ-1:0] irq_pend,
    input logic [NIRQ-1:0] irq_mask,
    input logic            o_redirect,
    input logic            o_err,
    input logic            o_crmd_we,
    input logic            o_dapg_we,
    input logic            o_prmd_we,
    input logic            o_rprmd_we,
    input logic            o_era_we,
    input logic            o_rera_we,
    input logic            o_stat_we,
    input logic            o_badv_we,
    input logic            o_badi_req,
    input logic            o_dbg_we,
    input logic            o_dbg_dcl,
    input logic [5:0]      o_dbg_code
);
    a_r13_redirect_has_source: assert property (@(posedge clk) disable iff (rst)
        o_redirect |-> $past(req_valid || (cur_ie && !dbg_active && ((irq_pend & irq_mask) != '0))));

    a_r2_no_irq_when_blocked: assert property (@(posedge clk) disable iff (rst)
        (!$past(req_valid) && (!$past(cur_ie) || $past(dbg_active) || $past((irq_pend & irq_mask) == '0)))
        |-> !o_redirect);

    a_r12_err_silent: assert property (@(posedge clk) disable iff (rst)
        o_err |-> !(o_redirect || o_crmd_we || o_prmd_we || o_rprmd_we || o_stat_we ||
                    o_era_we || o_dbg_we || o_badi_req || o_badv_we));

    a_r9_bp_debug_code: assert property (@(posedge clk) disable iff (rst)
        o_dbg_dcl |-> (o_dbg_we && o_dbg_code == 6'hC && !o_crmd_we));

    a_r6_refill_set: assert property (@(posedge clk) disable iff (rst)
        o_rprmd_we |-> (o_dapg_we && o_rera_we && !o_prmd_we && !o_stat_we && !o_era_we && $past(refill)));

    a_r8_entry_drops_mode: assert property (@(posedge clk) disable iff (rst)
        (o_prmd_we || o_rprmd_we) |-> (o_crmd_we && !o_dbg_we));
endmodule

bind trap_entry_unit trap_entry_sva #(.NIRQ(NIRQ)) u_sva (.*);

// File: tb/trap_entry_unit_bench.sv
module trap_entry_unit_bench;

    localparam int XLEN = 32;
    localparam int NIRQ = 13;
    localparam logic [31:0] BASE  = 32'h8000_0000;
    localparam logic [31:0] RBASE = 32'h9000_1000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic [5:0]      req_code = '0;
    logic [8:0]      req_sub = '0;
    logic [31:0]     cur_pc = '0;
    logic            refill = 1'b0;
    logic [1:0]      cur_plv = '0;
    logic            cur_ie = 1'b0;
    logic            dbg_active = 1'b0;
    logic [NIRQ-1:0] irq_pend = '0;
    logic [NIRQ-1:0] irq_mask = '0;
    logic [2:0]      vec_size = '0;

    logic            o_redirect, o_err, o_crmd_we, o_dapg_we, o_prmd_we, o_rprmd_we;
    logic [31:0]     o_redirect_pc, o_epc, o_rera;
    logic [1:0]      o_sv_plv;
    logic            o_sv_ie, o_era_we, o_rera_we, o_stat_we, o_badv_we, o_badi_req;
    logic            o_dbg_we, o_dbg_dcl, o_dbg_dei;
    logic [5:0]      o_ecode, o_dbg_code;
    logic [8:0]      o_esub;

    always #10 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN), .NIRQ(NIRQ)) u_trap_entry_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code), .req_sub(req_sub),
        .cur_pc(cur_pc), .refill(refill), .cur_plv(cur_plv), .cur_ie(cur_ie),
        .dbg_active(dbg_active), .irq_pend(irq_pend), .irq_mask(irq_mask),
        .vec_size(vec_size), .entry_base(BASE), .refill_base(RBASE),
        .o_redirect(o_redirect), .o_redirect_pc(o_redirect_pc), .o_err(o_err),
        .o_crmd_we(o_crmd_we), .o_dapg_we(o_dapg_we), .o_prmd_we(o_prmd_we),
        .o_rprmd_we(o_rprmd_we), .o_sv_plv(o_sv_plv), .o_sv_ie(o_sv_ie),
        .o_era_we(o_era_we), .o_epc(o_epc), .o_rera_we(o_rera_we), .o_rera(o_rera),
        .o_stat_we(o_stat_we), .o_ecode(o_ecode), .o_esub(o_esub),
        .o_badv_we(o_badv_we), .o_badi_req(o_badi_req), .o_dbg_we(o_dbg_we),
        .o_dbg_dcl(o_dbg_dcl), .o_dbg_dei(o_dbg_dei), .o_dbg_code(o_dbg_code)
    );

    // flag order: redirect err crmd dapg prmd rprmd era rera stat badv badi dbg dcl dei
    typedef struct packed {
        logic [13:0] fl;
        logic [31:0] pc;
        logic [31:0] epc;
        logic [31:0] rera;
        logic [5:0]  ec;
        logic [8:0]  es;
        logic [1:0]  sp;
        logic        si;
        logic [5:0]  dc;
    } obs_t;

    obs_t  q_exp[$];
    string q_tag[$];
    int    n_cmp = 0;
    int    n_bad = 0;

    function automatic obs_t model();
        obs_t e;
        logic [31:0] spc;
        logic [NIRQ-1:0] act;
        int hv;
        logic known, is_int, is_dbp, badv_c, nobadi, irq, norm, intr;
        e = '0;
        e.epc  = cur_pc;
        e.rera = cur_pc >> 2;
        spc = (vec_size == 0) ? 32'd0 : (32'd4 << vec_size);
        act = irq_pend & irq_mask;
        hv = 0;
        for (int i = NIRQ - 1; i >= 0; i--) if (act[i] && hv == 0) hv = i;
        known  = req_code inside {[0:9], [11:18], 26};
        is_int = (req_code == 0);
        is_dbp = (req_code == 26);
        badv_c = req_code inside {[11:18]};
        nobadi = (req_code == 0) || (req_code == 3) || (req_code == 8 && req_sub == 0);
        irq    = !req_valid && cur_ie && !dbg_active && (act != 0);
        if (req_valid && !known) begin
            e.fl[12] = 1'b1;
        end else if (req_valid && is_dbp) begin
            e.fl[13] = 1'b1; e.fl[2] = 1'b1; e.fl[1] = 1'b1; e.fl[3] = 1'b1;
            e.dc = 6'd12;
            e.pc = BASE + 32'h480;
        end else if (req_valid && is_int && dbg_active) begin
            e.fl[13] = 1'b1; e.fl[2] = 1'b1; e.fl[0] = 1'b1;
            e.pc = BASE + 32'h480;
        end else begin
            norm = req_valid || irq;
            intr = irq || (req_valid && is_int);
            if (norm) begin
                e.fl[13] = 1'b1; e.fl[11] = 1'b1;
                e.sp = cur_plv; e.si = cur_ie;
                e.fl[4] = !intr && badv_c;
                e.fl[3] = !intr && !nobadi;
                if (refill) begin
                    e.fl[8] = 1'b1; e.fl[10] = 1'b1; e.fl[6] = 1'b1;
                end else begin
                    e.fl[9] = 1'b1; e.fl[5] = 1'b1; e.fl[7] = 1'b1;
                    e.ec = intr ? 6'd0 : req_code;
                    e.es = intr ? 9'd0 : req_sub;
                end
                if (intr)        e.pc = BASE + (32'd64 + 32'(hv)) * spc;
                else if (refill) e.pc = RBASE;
                else             e.pc = BASE + 32'(req_code) * spc;
            end
        end
        return e;
    endfunction

    function automatic obs_t msk(obs_t o, obs_t e);
        obs_t r;
        r = o;
        if (!e.fl[13]) r.pc = '0;
        if (!(e.fl[7] || e.fl[4] || e.fl[2])) r.epc = '0;
        if (!e.fl[6]) r.rera = '0;
        if (!e.fl[5]) begin r.ec = '0; r.es = '0; end
        if (!(e.fl[9] || e.fl[8])) begin r.sp = '0; r.si = 1'b0; end
        if (!e.fl[1]) r.dc = '0;
        return r;
    endfunction

    function automatic obs_t got();
        obs_t g;
        g.fl   = {o_redirect, o_err, o_crmd_we, o_dapg_we, o_prmd_we, o_rprmd_we, o_era_we,
                  o_rera_we, o_stat_we, o_badv_we, o_badi_req, o_dbg_we, o_dbg_dcl, o_dbg_dei};
        g.pc   = o_redirect_pc;
        g.epc  = o_epc;
        g.rera = o_rera;
        g.ec   = o_ecode;
        g.es   = o_esub;
        g.sp   = o_sv_plv;
        g.si   = o_sv_ie;
        g.dc   = o_dbg_code;
        return g;
    endfunction

    // driver: inputs are set by the caller at a falling edge; push the expectation
    task automatic step(input string tag);
        q_exp.push_back(model());
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic quiet();
        req_valid = 1'b0; req_code = '0; req_sub = '0; refill = 1'b0;
        cur_ie = 1'b0; dbg_active = 1'b0; irq_pend = '0; irq_mask = '0;
    endtask

    task automatic exc(input logic [5:0] c, input logic [8:0] s, input logic rf, input string tag);
        quiet();
        req_valid = 1'b1; req_code = c; req_sub = s; refill = rf;
        step(tag);
    endtask

    // monitor: compare one cycle after each push
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() != 0) begin
                obs_t e, g;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                g = got();
                n_cmp++;
                if (msk(g, e) != msk(e, e)) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", t, msk(g, e), msk(e, e));
                end
            end
        end
    end

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cur_pc = 32'h1C00_0040; cur_plv = 2'd3; vec_size = 3'd0;
        repeat (3) @(negedge clk);
        n_cmp++;
        if ({o_redirect, o_err, o_crmd_we, o_prmd_we, o_rprmd_we, o_stat_we, o_dbg_we, o_badi_req} != '0) begin
            n_bad++;
            $display("FAIL R1: got strobes active expected all zero in reset");
        end
        rst = 1'b0;
        step("R1 idle after reset");

        // R2 interrupt gating
        quiet(); cur_ie = 1'b1; irq_pend = 13'h004; irq_mask = 13'h000; step("R2 masked");
        quiet(); cur_ie = 1'b0; irq_pend = 13'h004; irq_mask = 13'h004; step("R2 ie off");
        quiet(); cur_ie = 1'b1; dbg_active = 1'b1; irq_pend = 13'h004; irq_mask = 13'h004; step("R2 debug on");
        // R3/R4 vectoring
        quiet(); cur_ie = 1'b1; irq_pend = 13'h0A4; irq_mask = 13'h1FFF; vec_size = 3'd0;
        step("R4 zero spacing");
        quiet(); cur_ie = 1'b1; irq_pend = 13'h0A4; irq_mask = 13'h024; vec_size = 3'd1;
        step("R3 masked top bit");
        quiet(); cur_ie = 1'b1; irq_pend = 13'h1FFF; irq_mask = 13'h1FFF; vec_size = 3'd3;
        step("R3 R4 top vector");
        quiet(); step("R13 pulse ends");

        // R5 R7 R8 R11 exceptions
        vec_size = 3'd2; cur_pc = 32'h0000_2000; cur_plv = 2'd3;
        exc(6'd11, 9'd0, 1'b0, "R5 R11 syscall");
        cur_pc = 32'h0000_3004;
        exc(6'd1, 9'd5, 1'b0, "R7 R11 load page");
        exc(6'd3, 9'd0, 1'b0, "R11 fetch page no capture");
        exc(6'd8, 9'd0, 1'b0, "R11 fetch addr");
        exc(6'd8, 9'd1, 1'b0, "R11 data addr");
        exc(6'd18, 9'd2, 1'b0, "R11 fp exc");
        exc(6'd9, 9'd0, 1'b0, "R11 bound");
        quiet(); step("R13 idle");

        // R6 refill, with an enabled interrupt present
        cur_pc = 32'h1234_5678; cur_plv = 2'd2;
        quiet(); req_valid = 1'b1; req_code = 6'd1; refill = 1'b1; cur_ie = 1'b1;
        irq_pend = 13'h010; irq_mask = 13'h010; step("R6 refill exc");
        quiet(); cur_ie = 1'b1; refill = 1'b1; irq_pend = 13'h002; irq_mask = 13'h002; step("R6 R8 refill irq");

        // R9 R10 debug
        cur_pc = 32'h0000_4440;
        exc(6'd26, 9'd0, 1'b1, "R9 breakpoint refill set");
        quiet(); req_valid = 1'b1; req_code = 6'd0; dbg_active = 1'b1;
        irq_pend = 13'h008; irq_mask = 13'h008; step("R10 debug interrupt");
        quiet(); req_valid = 1'b1; req_code = 6'd0; irq_pend = 13'h108; irq_mask = 13'h1FF;
        step("R3 requested interrupt");

        // R12 unsupported
        exc(6'd10, 9'd0, 1'b0, "R12 code 10");
        exc(6'd19, 9'd0, 1'b0, "R12 code 19");
        exc(6'd63, 9'd3, 1'b0, "R12 code 63");

        // R13 back to back
        exc(6'd12, 9'd0, 1'b0, "R13 first");
        exc(6'd13, 9'd0, 1'b0, "R13 second");
        quiet(); step("R13 drop");
        quiet(); step("R13 idle");
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule